// File: doc/BRIEF.md
# Buffer-ID Queue Bank with Level Thresholds

This block holds small hardware FIFOs of 13-bit buffer identifiers that a host processor and packet-handling engines pass between them. Each identifier names one 2 KB buffer in external memory: it supplies address bits [23:11] of a 24-bit address. The block stores only the identifiers and never the buffers.

There are two kinds of queue. In a transmit queue, the host pushes by writing the queue's data register, and an engine pops through a strobe port that shows the head entry. In a receive queue, an engine pushes through a strobe port, and the host pops by reading the queue's data register. Every queue has a level readback and a programmable threshold. When the level crosses above the threshold, a sticky change bit is set. Change bits that are not masked drive one interrupt line. Pushes into a full queue are dropped and leave a sticky overflow bit.

The host side is a synchronous single-cycle register bus. It is 32 bits wide by default and can be built 16 bits wide. Read data appears on the cycle after the read strobe.

Top module: `bufid_qbank`

## Requirements
- R1: A host write to the data register of transmit queue q (q below N_TX) pushes bits [12:0] of the write data as one identifier and ignores bits above 12. `tx_head[q]` shows the oldest entry, `tx_avail[q]` is high while the queue is not empty, and a `tx_pop[q]` pulse removes the oldest entry.
- R2: A `rx_push[k]` pulse pushes `rx_push_id[k]` into receive queue N_TX+k. A host read of that queue's data register returns the oldest identifier, zero-extended, on `bus_rdata` in the next cycle, and removes it.
- R3: A host read of an empty receive queue returns all ones and leaves its level at zero. A `tx_pop` pulse on an empty transmit queue has no effect.
- R4: The level register of each queue reads back the number of identifiers it holds, from 0 to DEPTH.
- R5: Change bit q is set when queue q's level goes from at or below its threshold to above it. The threshold used is the value held before that cycle. The bit stays set until the host writes 1 to it in the change register. When a setting transition and a clear happen in the same cycle, the set wins.
- R6: `irq` is high exactly when some change bit is set whose mask bit is 0. A mask bit of 1 blocks that queue.
- R7: A push into a full queue with no pop in the same cycle is dropped. It sets overflow bit q, which is cleared by writing 1 to it in the overflow register.
- R8: A push and a pop on the same queue in the same cycle both take effect and leave the level unchanged. This holds when the queue is full, but not when it is empty.
- R9: After reset every queue is empty, every threshold is 0, all change and overflow bits are 0, all mask bits are 1, and `irq` is 0.
- R10: Queue q occupies byte offset 12*q, with the data register at +0, the level at +4 and the threshold at +8. The change, mask and overflow registers follow at 12*NQ, 12*NQ+4 and 12*NQ+8, with bit q standing for queue q. With BUS_W=16 every offset is increased by 2. Other addresses read 0, and writes to them are ignored. Reads of a transmit data register return 0, and writes to a receive data register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid the cycle after a read |
| irq | output | 1 | Interrupt, high while an unmasked change bit is set |
| tx_pop | input | N_TX | Engine pop strobes for the transmit queues |
| tx_head | output | N_TX*ID_W | Oldest identifier of each transmit queue |
| tx_avail | output | N_TX | Transmit queue not empty |
| rx_push | input | N_RX | Engine push strobes for the receive queues |
| rx_push_id | input | N_RX*ID_W | Identifiers pushed by the engine |

## Verification
The assertions assume that every input is a known 0 or 1 from the first clock edge on. They also assume that reset is applied for at least one edge before any access. Beyond that they put no limit on how strobes combine: engine pops of empty queues, pushes into full queues and clears that race a setting transition are all legal.

The stimulus meets these assumptions by driving every input to 0 before reset is released. It changes inputs only just after the falling edge. It deliberately includes all of these legal but awkward combinations, first in directed form and then in a long pseudo-random mix over the whole address map.

// File: rtl/bqb_pkg.sv
package bqb_pkg;
    typedef enum logic [2:0] {
        K_NONE,
        K_DATA,
        K_LEVEL,
        K_THR,
        K_CHG,
        K_MASK,
        K_OVF
    } reg_kind_e;
endpackage

// File: rtl/bqb_decode.sv
module bqb_decode
    import bqb_pkg::*;
#(
    parameter int NQ       = 4,
    parameter int AW       = 8,
    parameter int LANE_OFS = 0,
    localparam int QW      = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          cs,
    input  logic [AW-1:0] addr,
    output reg_kind_e     kind,
    output logic [QW-1:0] idx
);
    localparam int COMMON = NQ * 12;

    always_comb begin
        kind = K_NONE;
        idx  = '0;
        for (int q = 0; q < NQ; q++) begin
            if (addr == AW'(q * 12 + LANE_OFS)) begin
                kind = K_DATA;
                idx  = QW'(q);
            end
            if (addr == AW'(q * 12 + 4 + LANE_OFS)) begin
                kind = K_LEVEL;
                idx  = QW'(q);
            end
            if (addr == AW'(q * 12 + 8 + LANE_OFS)) begin
                kind = K_THR;
                idx  = QW'(q);
            end
        end
        if (addr == AW'(COMMON + LANE_OFS))     kind = K_CHG;
        if (addr == AW'(COMMON + 4 + LANE_OFS)) kind = K_MASK;
        if (addr == AW'(COMMON + 8 + LANE_OFS)) kind = K_OVF;
        if (!cs) begin
            kind = K_NONE;
            idx  = '0;
        end
    end
endmodule

// File: rtl/bqb_fifo.sv
module bqb_fifo #(
    parameter int ID_W  = 13,
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic [ID_W-1:0] head_id,
    output logic [LW-1:0]   level,
    input  logic            thr_we,
    input  logic [LW-1:0]   thr_wdata,
    output logic [LW-1:0]   thr,
    input  logic            clr_stat,
    output logic            stat,
    input  logic            clr_ovf,
    output logic            ovf
);
    typedef struct {
        logic [ID_W-1:0] mem [DEPTH];
        logic [PW-1:0]   rd;
        logic [PW-1:0]   wr;
        logic [LW-1:0]   lvl;
        logic [LW-1:0]   thr;
        logic            stat;
        logic            ovf;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     do_pop_d, do_push_d, above_now_d, above_next_d;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d          = s_q;
        do_pop_d     = pop && (s_q.lvl != '0);
        do_push_d    = push && ((s_q.lvl != LW'(DEPTH)) || do_pop_d);
        if (do_push_d) begin
            s_d.mem[s_q.wr] = push_id;
            s_d.wr          = bump(s_q.wr);
        end
        if (do_pop_d) s_d.rd = bump(s_q.rd);
        s_d.lvl      = s_q.lvl + LW'(do_push_d) - LW'(do_pop_d);
        if (thr_we) s_d.thr = thr_wdata;
        above_now_d  = s_q.lvl > s_q.thr;
        above_next_d = s_d.lvl > s_q.thr;
        s_d.stat     = (s_q.stat & ~clr_stat) | (above_next_d & ~above_now_d);
        s_d.ovf      = (s_q.ovf & ~clr_ovf) | (push & ~do_push_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.rd   <= '0;
            s_q.wr   <= '0;
            s_q.lvl  <= '0;
            s_q.thr  <= '0;
            s_q.stat <= 1'b0;
            s_q.ovf  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_id = s_q.mem[s_q.rd];
    assign level   = s_q.lvl;
    assign thr     = s_q.thr;
    assign stat    = s_q.stat;
    assign ovf     = s_q.ovf;

    // R4: level never exceeds the depth
    a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R3: popping an empty queue without a push keeps it empty
    a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level == '0) |=> (level == '0));

    // R7: push into a full queue with no pop is dropped and flagged
    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == LW'(DEPTH)) |=> (level == LW'(DEPTH) && ovf));

    // R8: push and pop together on a non-empty queue keep the level
    a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && level != '0) |=> $stable(level));

    // R5: change bit is sticky until cleared
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !clr_stat) |=> stat);
endmodule

// File: rtl/bufid_qbank.sv
module bufid_qbank
    import bqb_pkg::*;
#(
    parameter int ID_W  = 13,
    parameter int DEPTH = 8,
    parameter int N_TX  = 2,
    parameter int N_RX  = 2,
    parameter int BUS_W = 32,
    parameter int AW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_cs,
    input  logic                 bus_we,
    input  logic [AW-1:0]        bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic                 irq,
    input  logic [N_TX-1:0]      tx_pop,
    output logic [N_TX*ID_W-1:0] tx_head,
    output logic [N_TX-1:0]      tx_avail,
    input  logic [N_RX-1:0]      rx_push,
    input  logic [N_RX*ID_W-1:0] rx_push_id
);
    localparam int NQ       = N_TX + N_RX;
    localparam int LW       = $clog2(DEPTH + 1);
    localparam int QW       = (NQ > 1) ? $clog2(NQ) : 1;
    localparam int LANE_OFS = (BUS_W == 16) ? 2 : 0;

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
        logic [NQ-1:0]    mask;
    } top_st_t;

    top_st_t          t_d, t_q;
    reg_kind_e        kind;
    logic [QW-1:0]    idx;
    logic [BUS_W-1:0] rd_val_d;

    logic [NQ-1:0][ID_W-1:0] q_head;
    logic [NQ-1:0][LW-1:0]   q_lvl;
    logic [NQ-1:0][LW-1:0]   q_thr;
    logic [NQ-1:0]           q_stat;
    logic [NQ-1:0]           q_ovf;
    logic                    unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:ID_W];

    bqb_decode #(.NQ(NQ), .AW(AW), .LANE_OFS(LANE_OFS)) u_dec (
        .cs   (bus_cs),
        .addr (bus_addr),
        .kind (kind),
        .idx  (idx)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic            push, pop, data_hit;
        logic [ID_W-1:0] push_id;

        assign data_hit = (kind == K_DATA) && (idx == QW'(q));
        if (q < N_TX) begin : g_tx
            assign push    = data_hit && bus_we;
            assign push_id = bus_wdata[ID_W-1:0];
            assign pop     = tx_pop[q];
            assign tx_head[q*ID_W +: ID_W] = q_head[q];
            assign tx_avail[q] = (q_lvl[q] != '0);
        end else begin : g_rx
            assign push    = rx_push[q-N_TX];
            assign push_id = rx_push_id[(q-N_TX)*ID_W +: ID_W];
            assign pop     = data_hit && !bus_we;
        end

        bqb_fifo #(.ID_W(ID_W), .DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push),
            .push_id   (push_id),
            .pop       (pop),
            .head_id   (q_head[q]),
            .level     (q_lvl[q]),
            .thr_we    ((kind == K_THR) && (idx == QW'(q)) && bus_we),
            .thr_wdata (bus_wdata[LW-1:0]),
            .thr       (q_thr[q]),
            .clr_stat  ((kind == K_CHG) && bus_we && bus_wdata[q]),
            .stat      (q_stat[q]),
            .clr_ovf   ((kind == K_OVF) && bus_we && bus_wdata[q]),
            .ovf       (q_ovf[q])
        );
    end

    always_comb begin
        t_d = t_q;
        rd_val_d = '0;
        case (kind)
            K_DATA: begin
                if (int'(idx) >= N_TX)
                    rd_val_d = (q_lvl[idx] == '0) ? '1 : BUS_W'(q_head[idx]);
            end
            K_LEVEL: rd_val_d = BUS_W'(q_lvl[idx]);
            K_THR:   rd_val_d = BUS_W'(q_thr[idx]);
            K_CHG:   rd_val_d = BUS_W'(q_stat);
            K_MASK:  rd_val_d = BUS_W'(t_q.mask);
            K_OVF:   rd_val_d = BUS_W'(q_ovf);
            default: rd_val_d = '0;
        endcase
        if (bus_cs && !bus_we) t_d.rdata = rd_val_d;
        if (kind == K_MASK && bus_we) t_d.mask = bus_wdata[NQ-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.rdata <= '0;
            t_q.mask  <= '1;
        end else begin
            t_q <= t_d;
        end
    end

    assign bus_rdata = t_q.rdata;
    assign irq       = |(q_stat & ~t_q.mask);

    // R3: read of an empty receive queue answers all ones next cycle
    a_r3_empty_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_DATA && !bus_we && int'(idx) >= N_TX && q_lvl[idx] == '0)
        |=> (bus_rdata == '1));

    // R6: interrupt only with some change bit set
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (q_stat != '0));
endmodule

// File: tb/sim_bufid_qbank.sv
module sim_bufid_qbank;
    localparam int ID_W = 13, DEPTH = 8, N_TX = 2, N_RX = 2, NQ = 4;
    localparam int BUS_W = 32, AW = 8;

    logic                 clk = 0, rst_n = 0;
    logic                 cs = 0, we = 0;
    logic [AW-1:0]        addr = 0;
    logic [BUS_W-1:0]     wdata = 0;
    logic [BUS_W-1:0]     rdata;
    logic                 irq;
    logic [N_TX-1:0]      tx_pop = 0;
    logic [N_TX*ID_W-1:0] tx_head;
    logic [N_TX-1:0]      tx_avail;
    logic [N_RX-1:0]      rx_push = 0;
    logic [N_RX*ID_W-1:0] rx_id = 0;

    bufid_qbank #(.ID_W(ID_W), .DEPTH(DEPTH), .N_TX(N_TX), .N_RX(N_RX),
                  .BUS_W(BUS_W), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .tx_pop(tx_pop),
        .tx_head(tx_head), .tx_avail(tx_avail), .rx_push(rx_push),
        .rx_push_id(rx_id));

    always #4 clk = ~clk;

    int    errors = 0, checks = 0, cyc = 0;
    string phase = "R9";

    // reference model
    int mq[NQ][$];
    int mthr[NQ];
    bit mstat[NQ], movf[NQ];
    int mmask;
    int exp_rd;
    bit rd_pend;
    string rd_tag;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (phase %s) t=%0t actual=%h expected=%h",
                     tag, phase, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin : model
        int kind, qa, a, rv, oldn, newn;
        bit push, pop, dpush, dpop;
        int id;
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                mq[q].delete(); mthr[q] = 0; mstat[q] = 0; movf[q] = 0;
            end
            mmask = 4'hF; rd_pend = 0;
        end else begin
            // R10 address map
            kind = 0; qa = 0; a = int'(addr);
            if (cs) begin
                if (a < NQ*12 && a % 4 == 0) begin
                    qa = a / 12; kind = 1 + (a % 12) / 4;
                end else if (a == NQ*12) kind = 4;
                else if (a == NQ*12 + 4) kind = 5;
                else if (a == NQ*12 + 8) kind = 6;
            end
            rv = 0; rd_tag = "R10";
            case (kind)
                1: if (qa >= N_TX) begin
                       if (mq[qa].size() == 0) begin rv = -1; rd_tag = "R3"; end
                       else begin rv = mq[qa][0]; rd_tag = "R2"; end
                   end
                2: begin rv = mq[qa].size(); rd_tag = "R4"; end
                3: begin rv = mthr[qa]; rd_tag = "R5"; end
                4: begin for (int q = 0; q < NQ; q++) rv |= int'(mstat[q]) << q; rd_tag = "R5"; end
                5: begin rv = mmask; rd_tag = "R6"; end
                6: begin for (int q = 0; q < NQ; q++) rv |= int'(movf[q]) << q; rd_tag = "R7"; end
                default: rv = 0;
            endcase
            rd_pend = cs && !we;
            if (rd_pend) exp_rd = rv;
            for (int q = 0; q < NQ; q++) begin
                if (q < N_TX) begin
                    push = cs && we && kind == 1 && qa == q;
                    id   = int'(wdata[12:0]);
                    pop  = tx_pop[q];
                end else begin
                    push = rx_push[q-N_TX];
                    id   = int'(rx_id[(q-N_TX)*ID_W +: ID_W]);
                    pop  = cs && !we && kind == 1 && qa == q;
                end
                oldn  = mq[q].size();
                dpop  = pop && oldn > 0;
                dpush = push && (oldn < DEPTH || dpop);
                if (dpop) void'(mq[q].pop_front());
                if (dpush) mq[q].push_back(id);
                newn = mq[q].size();
                if (cs && we && kind == 4 && wdata[q]) mstat[q] = 0;
                if (newn > mthr[q] && !(oldn > mthr[q])) mstat[q] = 1;
                if (cs && we && kind == 6 && wdata[q]) movf[q] = 0;
                if (push && !dpush) movf[q] = 1;
                if (cs && we && kind == 3 && qa == q) mthr[q] = int'(wdata[3:0]);
            end
            if (cs && we && kind == 5) mmask = int'(wdata[3:0]);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit ei;
            ei = 0;
            for (int q = 0; q < NQ; q++) if (mstat[q] && !mmask[q]) ei = 1;
            check("R6 R9 irq", int'(irq), int'(ei));
            for (int q = 0; q < N_TX; q++) begin
                check("R1 avail", int'(tx_avail[q]), int'(mq[q].size() > 0));
                if (mq[q].size() > 0)
                    check("R1 R8 head", int'(tx_head[q*ID_W +: ID_W]), mq[q][0]);
            end
            if (rd_pend) check({rd_tag, " rdata"}, int'(rdata), exp_rd);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk); #1;
        cs = 0; we = 0; tx_pop = 0; rx_push = 0;
    endtask
    task automatic wr(int a, int d);
        cs = 1; we = 1; addr = AW'(a); wdata = BUS_W'(d); tick();
    endtask
    task automatic rd(int a);
        cs = 1; we = 0; addr = AW'(a); tick();
    endtask
    task automatic epush(int k, int id);
        rx_push[k] = 1; rx_id[k*ID_W +: ID_W] = ID_W'(id); tick();
    endtask

    initial begin
        int r;
        r = 32'h1234_5677;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        phase = "R9";
        rd(4); rd(8); rd(40); rd(48); rd(52); rd(56); rd(24);
        phase = "R10";
        wr(1, 5); wr(63, 7); rd(1); rd(60); rd(0); wr(24, 9); rd(28);
        phase = "R1";
        wr(0, 32'hFFFF_E005); wr(0, 32'h0000_1FFF); wr(0, 3); rd(4);
        repeat (4) begin tx_pop[0] = 1; tick(); end
        rd(4);
        phase = "R2";
        epush(0, 11); epush(0, 22); epush(1, 33); rd(28); rd(24); rd(24); rd(28); rd(36);
        phase = "R3";
        rd(24); rd(28); rd(36); tx_pop[1] = 1; tick(); rd(16);
        phase = "R5";
        wr(8, 2); wr(52, 0);
        wr(0, 1); wr(0, 2); rd(48); wr(0, 3); rd(48); wr(48, 1); rd(48);
        wr(0, 4); rd(48);
        tx_pop[0] = 1; tick(); tx_pop[0] = 1; tick(); wr(0, 5); rd(48);
        wr(52, 4'hF); tick(); wr(52, 4'h0);
        wr(32, 1); epush(0, 1); epush(0, 2);
        rx_push[0] = 1; rx_id[12:0] = 7; cs = 1; we = 1; addr = 48; wdata = 4; tick();
        rd(48); wr(48, 15); rd(48);
        phase = "R7";
        repeat (9) wr(12, 100);
        rd(16); rd(56); wr(56, 2); rd(56);
        phase = "R8";
        tx_pop[1] = 1; cs = 1; we = 1; addr = 12; wdata = 200; tick(); rd(16);
        repeat (8) epush(1, 50);
        rx_push[1] = 1; rx_id[25:13] = 60; cs = 1; we = 0; addr = 36; tick(); rd(40); rd(56);
        phase = "mix";
        for (int i = 0; i < 3000; i++) begin
            r = r ^ (r << 13); r = r ^ (r >>> 17); r = r ^ (r << 5);
            tx_pop = 2'(r >> 3); rx_push = 2'(r >> 5);
            rx_id = 26'(r >> 6);
            if (r[1]) begin
                cs = 1; we = r[2];
                addr = AW'((r >> 8) % 64);
                if (r[9]) addr = AW'(((r >> 10) % 15) * 4);
                wdata = BUS_W'(r >> 4);
            end
            tick();
        end
        repeat (3) tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule